// File: doc/BRIEF.md
# Dual Seven-Segment Refresh Monitor

This block sits beside a 32-bit output-data register whose bits drive two multiplexed seven-segment digits. Each time that register is updated (by a set, a clear or a masked direct write) the surrounding logic presents the word as it was before the update and the word as it is after, together with a one-cycle write strobe. The monitor decodes the new word into one 8-bit segment vector per digit and raises a one-cycle refresh pulse when the update changed a bit that can alter what the display shows.

The two digit commons are active low, and a separate blank bit darkens both digits whatever the commons say. The eight segment bits are spread over a contiguous field in a scattered order. The monitor repacks them into the conventional order {dp, g, f, e, d, c, b, a}, so that a downstream renderer or a check needs no knowledge of the pin mapping. A refresh is only raised when the change can be seen, which depends on whether any digit is enabled and whether blanking is active.

The strobe is a plain control pin. The block has no back-pressure: every strobe is taken on the clock edge where it is high, and the outputs change only on such edges.

Top module: `ssd_refresh_monitor`

## Requirements
- R1: After reset both segment vectors are 0, the blank flag is 1 and the refresh pulse is 0.
- R2: Digit 0 is enabled when word bit 28 is 0 and digit 1 is enabled when word bit 30 is 0. The segment vector of a disabled digit is all zero.
- R3: When word bit 31 is 1 the blank flag is 1 and both segment vectors are all zero. The blank flag always equals bit 31 of the last strobed word.
- R4: On an enabled, unblanked digit, output bit k is 1 exactly when its source bit is 1. The sources are: k0 (a, top) from bit 25, k1 (b, upper right) from bit 24, k2 (c, lower right) from bit 22, k3 (d, bottom) from bit 21, k4 (e, lower left) from bit 20, k5 (f, upper left) from bit 27, k6 (g, middle) from bit 26, and k7 (decimal point) from bit 23.
- R5: A strobed change in any of bits 20..27 raises refresh only if, in the new word, bit 31 is 0 and at least one of bits 28 and 30 is 0.
- R6: A strobed change in bit 28 or bit 30 raises refresh only if bit 31 of the new word is 0.
- R7: A strobed change in bit 31 raises refresh only if at least one of bits 28 and 30 is 0 in the new word.
- R8: Changes confined to bits 0..19 and bit 29, or a strobe with identical old and new words, never raise refresh.
- R9: Refresh and the new segment and blank values appear one clock after the strobed edge, and refresh lasts one cycle. Without a strobe the outputs hold and the words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe marking an update of the output-data word |
| prev_word | input | 32 | Output-data word before the update |
| cur_word | input | 32 | Output-data word after the update |
| seg0_o | output | 8 | Digit 0 segments, {dp,g,f,e,d,c,b,a} |
| seg1_o | output | 8 | Digit 1 segments, {dp,g,f,e,d,c,b,a} |
| blank_o | output | 1 | Display blanked |
| refresh_o | output | 1 | One-cycle visible-change pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit word, the segment field at bits 20..27, the commons at 28 and 30 with a stride of 2, and the blank bit at 31. This layout brings every qualification corner within reach. Tested cases include a segment change with both commons high, a common change while blanked, unblanking with no digit enabled, and a lone change in bit 29, which lies between the two commons. Single-segment words check the repacking bit by bit. Random word pairs that differ in one bit, with the commons and the blank bit biased low, then sweep the remaining combinations.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int SEG_COUNT = 8;
  typedef logic [SEG_COUNT-1:0] seg_vec_t;

  // position of each segment inside the raw field, relative to its base bit
  localparam int RAW_E  = 0;
  localparam int RAW_D  = 1;
  localparam int RAW_C  = 2;
  localparam int RAW_DP = 3;
  localparam int RAW_B  = 4;
  localparam int RAW_A  = 5;
  localparam int RAW_G  = 6;
  localparam int RAW_F  = 7;

  // repack the scattered field into {dp,g,f,e,d,c,b,a}
  function automatic seg_vec_t pack_segments(input seg_vec_t raw);
    return {raw[RAW_DP], raw[RAW_G], raw[RAW_F], raw[RAW_E],
            raw[RAW_D], raw[RAW_C], raw[RAW_B], raw[RAW_A]};
  endfunction
endpackage

// File: rtl/ssd_digit_dec.sv
module ssd_digit_dec
  import ssd_pkg::*;
(
  input  seg_vec_t seg_raw,
  input  logic     com_n,
  input  logic     blank,
  output seg_vec_t seg
);
  // a digit shows its segments only when its common is low and no blanking
  always_comb begin
    if (blank || com_n) seg = '0;
    else                seg = pack_segments(seg_raw);
  end
endmodule

// File: rtl/ssd_change_qual.sv
module ssd_change_qual
  import ssd_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  seg_vec_t          prev_seg,
  input  seg_vec_t          cur_seg,
  input  logic [DIGITS-1:0] prev_com,
  input  logic [DIGITS-1:0] cur_com,
  input  logic              prev_blank,
  input  logic              cur_blank,
  output logic              hit
);
  logic seg_chg, com_chg, blank_chg, any_lit;

  always_comb begin
    seg_chg   = |(prev_seg ^ cur_seg);
    com_chg   = |(prev_com ^ cur_com);
    blank_chg = prev_blank ^ cur_blank;
    any_lit   = ~&cur_com;
    // each class of change is qualified by the state of the new word
    hit = (seg_chg & any_lit & ~cur_blank)
        | (com_chg & ~cur_blank)
        | (blank_chg & any_lit);
  end
endmodule

// File: rtl/ssd_refresh_monitor.sv
module ssd_refresh_monitor
  import ssd_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int SEG_LSB    = 20,
  parameter int COM_LSB    = 28,
  parameter int COM_STRIDE = 2,
  parameter int BLANK_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] prev_word,
  input  logic [WORD_W-1:0] cur_word,
  output logic [7:0]        seg0_o,
  output logic [7:0]        seg1_o,
  output logic              blank_o,
  output logic              refresh_o
);
  localparam int DIGITS = 2;

  seg_vec_t          prev_seg, cur_seg;
  logic [DIGITS-1:0] prev_com, cur_com;
  logic              prev_blank, cur_blank;
  logic              hit;
  seg_vec_t          seg_next [DIGITS];
  seg_vec_t          seg_q    [DIGITS];
  logic              blank_q, refresh_q;
  logic              unused_word_bits;

  assign prev_seg   = prev_word[SEG_LSB +: SEG_COUNT];
  assign cur_seg    = cur_word[SEG_LSB +: SEG_COUNT];
  assign prev_blank = prev_word[BLANK_BIT];
  assign cur_blank  = cur_word[BLANK_BIT];
  assign unused_word_bits = ^{prev_word, cur_word};

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    localparam int COM_BIT = COM_LSB + COM_STRIDE * d;
    assign prev_com[d] = prev_word[COM_BIT];
    assign cur_com[d]  = cur_word[COM_BIT];

    ssd_digit_dec u_dec (
      .seg_raw (cur_seg),
      .com_n   (cur_com[d]),
      .blank   (cur_blank),
      .seg     (seg_next[d])
    );
  end

  ssd_change_qual #(.DIGITS(DIGITS)) u_qual (
    .prev_seg   (prev_seg),
    .cur_seg    (cur_seg),
    .prev_com   (prev_com),
    .cur_com    (cur_com),
    .prev_blank (prev_blank),
    .cur_blank  (cur_blank),
    .hit        (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q[0]  <= '0;
      seg_q[1]  <= '0;
      blank_q   <= 1'b1;
      refresh_q <= 1'b0;
    end else begin
      refresh_q <= wr_stb & hit;
      if (wr_stb) begin
        seg_q[0] <= seg_next[0];
        seg_q[1] <= seg_next[1];
        blank_q  <= cur_blank;
      end
    end
  end

  assign seg0_o    = seg_q[0];
  assign seg1_o    = seg_q[1];
  assign blank_o   = blank_q;
  assign refresh_o = refresh_q;
endmodule

// File: rtl/ssd_refresh_monitor_chk.sv
module ssd_refresh_monitor_chk #(
  parameter int WORD_W    = 32,
  parameter int COM0_BIT  = 28,
  parameter int BLANK_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [WORD_W-1:0] prev_word,
  input logic [WORD_W-1:0] cur_word,
  input logic [7:0]        seg0_o,
  input logic [7:0]        seg1_o,
  input logic              blank_o,
  input logic              refresh_o
);
  AST_REFRESH_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> $past(wr_stb)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(seg0_o) && $stable(seg1_o) && $stable(blank_o) && !refresh_o)); // R9
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> (seg0_o == 8'h00 && seg1_o == 8'h00)); // R3
  AST_BLANK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (blank_o == $past(cur_word[BLANK_BIT]))); // R3
  AST_QUIET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && prev_word == cur_word) |=> !refresh_o); // R8
  AST_DIGIT0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cur_word[COM0_BIT]) |=> (seg0_o == 8'h00)); // R2
endmodule

bind ssd_refresh_monitor ssd_refresh_monitor_chk #(
  .WORD_W(WORD_W), .COM0_BIT(COM_LSB), .BLANK_BIT(BLANK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .prev_word(prev_word),
  .cur_word(cur_word), .seg0_o(seg0_o), .seg1_o(seg1_o),
  .blank_o(blank_o), .refresh_o(refresh_o)
);

// File: tb/tb_ssd_refresh_monitor.sv
module tb_ssd_refresh_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [31:0] prev_word = '0;
  logic [31:0] cur_word = '0;
  logic [7:0]  seg0_o, seg1_o;
  logic        blank_o, refresh_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  // expected outputs for the next comparison
  logic [7:0] e_seg0 = '0, e_seg1 = '0;
  logic       e_blank = 1'b1, e_refresh = 1'b0;
  string      e_tag = "R1";

  ssd_refresh_monitor dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .prev_word(prev_word),
    .cur_word(cur_word), .seg0_o(seg0_o), .seg1_o(seg1_o),
    .blank_o(blank_o), .refresh_o(refresh_o)
  );

  always #4 clk = ~clk;

  // output slot of a segment source bit: a,b,c,d,e,f,g,dp = 0..7
  function automatic int slot_of(input int b);
    case (b)
      25: return 0; 24: return 1; 22: return 2; 21: return 3;
      20: return 4; 27: return 5; 26: return 6; 23: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] model_seg(input logic [31:0] w, input int com);
    logic [7:0] r = '0;
    if (w[31] || w[com]) return r;
    for (int b = 20; b <= 27; b++)
      if (w[b]) r[slot_of(b)] = 1'b1;
    return r;
  endfunction

  function automatic logic model_refresh(input logic [31:0] p, input logic [31:0] c);
    logic lit = !c[28] || !c[30];
    logic r = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (p[i] != c[i]) begin
        if (i >= 20 && i <= 27 && lit && !c[31]) r = 1'b1;
        if ((i == 28 || i == 30) && !c[31])      r = 1'b1;
        if (i == 31 && lit)                      r = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic compare();
    compared++;
    if (seg0_o !== e_seg0 || seg1_o !== e_seg1 || blank_o !== e_blank || refresh_o !== e_refresh) begin
      mismatched++;
      $display("FAIL %s: got seg0=%h seg1=%h blank=%b refresh=%b, expected seg0=%h seg1=%h blank=%b refresh=%b",
               e_tag, seg0_o, seg1_o, blank_o, refresh_o, e_seg0, e_seg1, e_blank, e_refresh);
    end
  endtask

  // compare the previous cycle's result, then drive the next inputs
  task automatic step(input logic [31:0] p, input logic [31:0] c, input logic s, input string tag);
    @(negedge clk);
    compare();
    prev_word = p;
    cur_word  = c;
    wr_stb    = s;
    e_tag     = tag;
    if (s) begin
      e_seg0    = model_seg(c, 28);
      e_seg1    = model_seg(c, 30);
      e_blank   = c[31];
      e_refresh = model_refresh(p, c);
    end else begin
      e_refresh = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    logic [31:0] w, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state is compared by the first step
    step(32'h0, 32'h0, 1'b0, "R1");
    // R4: each segment alone on digit 0 (bit 30 high disables digit 1)
    for (int b = 20; b <= 27; b++)
      step(32'h4000_0000, 32'h4000_0000 | (32'h1 << b), 1'b1, "R4");
    // R2: digit 1 only, then both digits, then neither
    step(32'h0, 32'h1FF0_0000, 1'b1, "R2");
    step(32'h1FF0_0000, 32'h0FF0_0000, 1'b1, "R2");
    step(32'h0FF0_0000, 32'h5FF0_0000, 1'b1, "R2");
    // R5: segment change with no digit enabled, then with one enabled
    step(32'h5FF0_0000, 32'h5A50_0000, 1'b1, "R5");
    step(32'h4A50_0000, 32'h4A60_0000, 1'b1, "R5");
    // R3: blank on with a digit enabled, then segment change while blanked
    step(32'h4A60_0000, 32'hCA60_0000, 1'b1, "R3");
    step(32'hCA60_0000, 32'hCAF0_0000, 1'b1, "R5");
    // R6: common change while blanked, then while unblanked
    step(32'hCAF0_0000, 32'hDAF0_0000, 1'b1, "R6");
    step(32'h4AF0_0000, 32'h5AF0_0000, 1'b1, "R6");
    // R7: unblank with no digit enabled, then blank with a digit enabled
    step(32'hDAF0_0000, 32'h5AF0_0000, 1'b1, "R7");
    step(32'h0AF0_0000, 32'h8AF0_0000, 1'b1, "R7");
    // R8: low bits and bit 29 change, identical words
    step(32'h0AF0_0000, 32'h0AFF_FFFF, 1'b1, "R8");
    step(32'h0AFF_FFFF, 32'h2AFF_FFFF, 1'b1, "R8");
    step(32'h2AFF_FFFF, 32'h2AFF_FFFF, 1'b1, "R8");
    // R9: no strobe with a visible difference, then back-to-back strobes
    step(32'h0000_0000, 32'h0FF0_0000, 1'b0, "R9");
    step(32'h0000_0000, 32'h0FF0_0000, 1'b0, "R9");
    step(32'h0000_0000, 32'h0FF0_0000, 1'b1, "R9");
    step(32'h0FF0_0000, 32'h0F00_0000, 1'b1, "R9");
    step(32'h0F00_0000, 32'h0F00_0000, 1'b0, "R9");
    // random sweep with commons and blank biased low, one-bit differences
    for (int n = 0; n < 3000; n++) begin
      w = $urandom;
      if ($urandom % 2) w[31] = 1'b0;
      if ($urandom % 2) w[28] = 1'b0;
      if ($urandom % 3 == 0) w[30] = 1'b0;
      p = ($urandom % 8 == 0) ? w : (w ^ (32'h1 << ($urandom % 32)));
      step(p, w, ($urandom % 4) != 0, "R5");
    end
    step(32'h0, 32'h0, 1'b0, "R9");
    step(32'h0, 32'h0, 1'b0, "R9");
    done = 1;
    finish_run();
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      compared++;
      $display("FAIL R9: watchdog expired, got %0d cycles, expected fewer than 100000", cycles);
      finish_run();
    end
  end
endmodule